// File: doc/BRIEF.md
# Address-Collision Busy Arbiter

Two ports share one memory array, and each may read or write any location at any time. This block watches both ports every clock cycle. When both ports are enabled and present the same address, it grants the location to one port and raises an active-low busy indication toward the other. The write of the losing port is suppressed in that same cycle. Once the addresses differ, busy is withdrawn.

A mode input lets several of these blocks run side by side to build a wider data word. In master mode the block arbitrates on its own and drives its busy outputs. In slave mode it does not arbitrate. It holds its busy outputs inactive and takes busy from outside, from the master's outputs, and uses that external busy only to block writes. All slices of the word therefore refuse the same write.

The busy and write-permit outputs are combinational, so a write is blocked in the cycle of the collision. The only state is the last cycle's port activity and the identity of the current winner. A write that is blocked is dropped, not held back for later.

Top module: `collision_arbiter`

## Requirements
- R1: After a synchronous reset there is no history of earlier accesses. With no address match, both busy outputs are high (1) and an enabled port's write request passes to its write-permit output. A match that is present when reset is released is arbitrated as a simultaneous arrival.
- R2: A match exists only when both port enables are 1 and the two addresses are equal. A port whose enable is 0 never causes busy, and its write-permit output is 0.
- R3: In master mode, if a match begins and both ports changed their enable or address in that cycle, the left port wins. r_busy_n is then 0 and l_busy_n is 1.
- R4: In master mode, if a match begins and exactly one port kept the same enable and address as in the previous cycle, that port wins. The port that arrived in this cycle gets busy (0).
- R5: The winner of a match keeps access for every consecutive cycle the match lasts. This includes cycles spent in slave mode.
- R6: In the first cycle the addresses no longer match, both busy outputs return to 1.
- R7: In master mode the busy port's write-permit output is 0 even while it requests a write. The winning port's write passes.
- R8: In slave mode (master_sel = 0) both busy outputs stay 1 whatever the addresses do.
- R9: In slave mode a port's write-permit output is 0 while its external busy input is 0, and it follows the write request while that input is 1. An internal address match has no effect on writes.
- R10: A blocked write is dropped. A write-permit output is 1 only in a cycle in which its own port is enabled and requests a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_sel | input | 1 | 1 = master (arbitrate, drive busy), 0 = slave (use external busy) |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | External busy for the left port, active low (slave mode) |
| r_busy_in_n | input | 1 | External busy for the right port, active low (slave mode) |
| l_busy_n | output | 1 | Busy to the left port, active low (master mode) |
| r_busy_n | output | 1 | Busy to the right port, active low (master mode) |
| l_wr_ok | output | 1 | Left write permitted to reach the array |
| r_wr_ok | output | 1 | Right write permitted to reach the array |

## Verification
A collision's start and a write request can fall in the same cycle. The bench provokes this by moving one or both ports onto a shared address while they request writes. It then judges the busy outputs and the write-permit outputs together before the next edge. The owner kept across a mode change is checked as well: the match runs on through slave-mode cycles, master mode returns, and the original winner must still hold the location.

// File: rtl/collision_arbiter_pkg.sv
// Package: shared types for the collision arbiter.
// Assumes: only two ports, left and right.
package collision_arbiter_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/arb_addr_compare.sv
// Module: arb_addr_compare
// Detects a live address match between the two ports. It also reports, for
// each port, whether that port kept its enable and address since the last
// cycle, which marks it as the earlier arrival.
// Assumes: synchronous active-low reset clears the history to "not enabled".
module arb_addr_compare #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              match,
    output logic              l_stayed,
    output logic              r_stayed
);
    logic              l_en_q, r_en_q;
    logic [ADDR_W-1:0] l_addr_q, r_addr_q;

    // Record last cycle's port activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_en_q   <= 1'b0;
            r_en_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            l_en_q   <= l_en;
            r_en_q   <= r_en;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    // Compare the addresses and flag the ports that held still.
    always_comb begin
        match    = l_en && r_en && (l_addr == r_addr);
        l_stayed = l_en && l_en_q && (l_addr == l_addr_q);
        r_stayed = r_en && r_en_q && (r_addr == r_addr_q);
    end

    AST_MATCH_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (l_en && r_en)); // R2
endmodule

// File: rtl/arb_win_tracker.sv
// Module: arb_win_tracker
// Picks the winner when a match starts and holds it while the match lasts.
// A new match goes to the port that held still. If both or neither held
// still, the left port wins.
// Assumes: match, l_stayed and r_stayed come from arb_addr_compare.
module arb_win_tracker
    import collision_arbiter_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   match,
    input  logic   l_stayed,
    input  logic   r_stayed,
    output owner_e winner
);
    owner_e owner_q;

    // Choose the owner: keep the current one, or decide a fresh match.
    always_comb begin
        if (!match)
            winner = OWN_NONE;
        else if (owner_q != OWN_NONE)
            winner = owner_q;
        else if (r_stayed && !l_stayed)
            winner = OWN_RIGHT;
        else
            winner = OWN_LEFT;
    end

    // Remember the owner for the next cycle of the same match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owner_q <= OWN_NONE;
        else
            owner_q <= winner;
    end

    AST_HOLD_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(match) && match) |-> (winner == $past(winner))); // R5
    AST_WINNER_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (winner != OWN_NONE)); // R2
endmodule

// File: rtl/arb_busy_mux.sv
// Module: arb_busy_mux
// Selects the busy source by mode and gates the write requests. In master
// mode busy comes from the internal winner. In slave mode the busy outputs
// stay released and only the external busy inputs block writes.
// Assumes: the external busy inputs are active low.
module arb_busy_mux
    import collision_arbiter_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   master_sel,
    input  owner_e winner,
    input  logic   l_en,
    input  logic   l_wr,
    input  logic   r_en,
    input  logic   r_wr,
    input  logic   l_busy_in_n,
    input  logic   r_busy_in_n,
    output logic   l_busy_n,
    output logic   r_busy_n,
    output logic   l_wr_ok,
    output logic   r_wr_ok
);
    logic l_block_n, r_block_n;

    // Drive busy and the write gates from the mode-selected source.
    always_comb begin
        l_busy_n = !(master_sel && (winner == OWN_RIGHT));
        r_busy_n = !(master_sel && (winner == OWN_LEFT));
        l_block_n = master_sel ? l_busy_n : l_busy_in_n;
        r_block_n = master_sel ? r_busy_n : r_busy_in_n;
        l_wr_ok  = l_en && l_wr && l_block_n;
        r_wr_ok  = r_en && r_wr && r_block_n;
    end

    AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!l_busy_n, !r_busy_n})); // R3
    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (l_busy_n && r_busy_n)); // R8
    AST_SLAVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && !l_busy_in_n) |-> !l_wr_ok); // R9
    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !r_busy_n |-> !r_wr_ok); // R7
    AST_WR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr_ok |-> (l_en && l_wr)) and (r_wr_ok |-> (r_en && r_wr))); // R10
endmodule

// File: rtl/collision_arbiter.sv
// Module: collision_arbiter (top)
// Two-port address-collision arbiter with master/slave busy handling.
// Busy and write-permit outputs are combinational from the current inputs
// and the registered winner, so a collision blocks a write in its own cycle.
// Assumes: synchronous active-low reset; one clock for both ports.
module collision_arbiter
    import collision_arbiter_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    logic   match, l_stayed, r_stayed;
    owner_e winner;

    arb_addr_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .l_en     (l_en),
        .l_addr   (l_addr),
        .r_en     (r_en),
        .r_addr   (r_addr),
        .match    (match),
        .l_stayed (l_stayed),
        .r_stayed (r_stayed)
    );

    arb_win_tracker u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .l_stayed (l_stayed),
        .r_stayed (r_stayed),
        .winner   (winner)
    );

    arb_busy_mux u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_sel  (master_sel),
        .winner      (winner),
        .l_en        (l_en),
        .l_wr        (l_wr),
        .r_en        (r_en),
        .r_wr        (r_wr),
        .l_busy_in_n (l_busy_in_n),
        .r_busy_in_n (r_busy_in_n),
        .l_busy_n    (l_busy_n),
        .r_busy_n    (r_busy_n),
        .l_wr_ok     (l_wr_ok),
        .r_wr_ok     (r_wr_ok)
    );

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (l_addr != r_addr) |-> (l_busy_n && r_busy_n)); // R6
endmodule

// File: tb/tb_collision_arbiter.sv
// Bench for collision_arbiter: a vector table walked cycle by cycle, then
// directed reset checks.
module tb_collision_arbiter;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          master_sel, l_en, l_wr, r_en, r_wr, l_busy_in_n, r_busy_in_n;
    logic [AW-1:0] l_addr, r_addr;
    logic          l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    collision_arbiter #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
        .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
    );

    typedef struct packed {
        logic          m;
        logic          le;
        logic [AW-1:0] la;
        logic          lw;
        logic          re;
        logic [AW-1:0] ra;
        logic          rw;
        logic          lbi;
        logic          rbi;
        logic [3:0]    exp;   // {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok}
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,8'h10,1'b1, 1'b1,8'h20,1'b1, 1'b1,1'b1, 4'b1111, 8'd2},
        '{1'b1,1'b1,8'h30,1'b0, 1'b0,8'h30,1'b1, 1'b1,1'b1, 4'b1100, 8'd2},
        '{1'b1,1'b1,8'h40,1'b1, 1'b1,8'h40,1'b1, 1'b1,1'b1, 4'b1010, 8'd3},
        '{1'b1,1'b1,8'h40,1'b1, 1'b1,8'h40,1'b1, 1'b1,1'b1, 4'b1010, 8'd5},
        '{1'b1,1'b1,8'h41,1'b1, 1'b1,8'h40,1'b1, 1'b1,1'b1, 4'b1111, 8'd6},
        '{1'b1,1'b1,8'h40,1'b1, 1'b1,8'h40,1'b1, 1'b1,1'b1, 4'b0101, 8'd4},
        '{1'b1,1'b1,8'h40,1'b0, 1'b1,8'h40,1'b1, 1'b1,1'b1, 4'b0101, 8'd5},
        '{1'b1,1'b0,8'h40,1'b0, 1'b1,8'h40,1'b1, 1'b1,1'b1, 4'b1101, 8'd2},
        '{1'b1,1'b1,8'h40,1'b0, 1'b1,8'h40,1'b0, 1'b1,1'b1, 4'b0100, 8'd4},
        '{1'b1,1'b1,8'h40,1'b1, 1'b1,8'h40,1'b0, 1'b1,1'b1, 4'b0100, 8'd7},
        '{1'b1,1'b1,8'h50,1'b0, 1'b1,8'h40,1'b0, 1'b1,1'b1, 4'b1100, 8'd10},
        '{1'b0,1'b1,8'h60,1'b1, 1'b1,8'h60,1'b1, 1'b1,1'b1, 4'b1111, 8'd8},
        '{1'b0,1'b1,8'h60,1'b1, 1'b1,8'h60,1'b1, 1'b0,1'b1, 4'b1101, 8'd9},
        '{1'b0,1'b1,8'h60,1'b1, 1'b1,8'h60,1'b1, 1'b1,1'b0, 4'b1110, 8'd9},
        '{1'b0,1'b1,8'h60,1'b0, 1'b1,8'h60,1'b0, 1'b0,1'b0, 4'b1100, 8'd9},
        '{1'b0,1'b1,8'h60,1'b0, 1'b1,8'h60,1'b0, 1'b1,1'b1, 4'b1100, 8'd10},
        '{1'b1,1'b1,8'h60,1'b1, 1'b1,8'h60,1'b1, 1'b1,1'b1, 4'b1010, 8'd5}
    };

    task automatic drive(input vec_t v);
        master_sel  = v.m;
        l_en        = v.le;  l_addr = v.la;  l_wr = v.lw;
        r_en        = v.re;  r_addr = v.ra;  r_wr = v.rw;
        l_busy_in_n = v.lbi; r_busy_in_n = v.rbi;
    endtask

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {l_busy_n,r_busy_n,l_wr_ok,r_wr_ok} actual %b expected %b",
                     tag, act, exp);
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive('{1'b1,1'b0,8'h00,1'b0, 1'b0,8'h00,1'b0, 1'b1,1'b1, 4'b0, 8'd0});
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: after reset, no match: busy released, writes pass.
        drive('{1'b1,1'b1,8'h01,1'b1, 1'b1,8'h02,1'b1, 1'b1,1'b1, 4'b0, 8'd1});
        #1 check("R1 reset state", 4'b1111);

        // Vector table, one cycle per entry.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1 check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
        end

        // R1: build a match won by the right port, reset across it, release.
        @(negedge clk);
        drive('{1'b1,1'b1,8'h70,1'b1, 1'b1,8'h71,1'b1, 1'b1,1'b1, 4'b0, 8'd1});
        @(negedge clk);
        drive('{1'b1,1'b1,8'h71,1'b1, 1'b1,8'h71,1'b1, 1'b1,1'b1, 4'b0, 8'd4});
        #1 check("R4 right holds before reset", 4'b0101);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 match at reset release goes to left", 4'b1010);
        @(negedge clk);
        #1 check("R5 left keeps after reset", 4'b1010);

        // R6 and R10: release and no late write.
        @(negedge clk);
        drive('{1'b1,1'b1,8'h72,1'b0, 1'b1,8'h71,1'b1, 1'b1,1'b1, 4'b0, 8'd6});
        #1 check("R6 released, no queued write", 4'b1101);

        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule